// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Port with Odd-Parity Option

This block is a transmitter and a receiver for asynchronous serial data. Both run from one system clock. They advance only on a single-cycle tick input, which an external timer supplies at sixteen times the bit rate. A write strobe hands a byte to the transmitter. The last received character is always present on the read-data output. A read strobe acknowledges that character and clears the sticky framing error.

The transmitter always sends eight bit slots followed by two stop bits. When odd parity is selected, the top slot carries a parity bit computed over the seven low data bits, so the frame length does not change. The receiver needs only one stop bit. When parity is selected, bit 7 of the received byte is replaced by a parity-error flag. Each completed character in either direction produces a one-cycle done pulse for an interrupt controller.

Top module: `serial_port`

## Requirements
- R1: After reset the line output is high (idle), the busy and both done outputs are low, the framing error is low and the read data is 0x00.
- R2: A transmitted frame is one low start bit, eight bit slots sent least significant first, and two high stop bits, each lasting 16 ticks.
- R3: With parity mode on, the transmitter sends data bits 6..0 unchanged and places an odd-parity bit in slot 7 (1 when bits 6..0 hold an even number of ones); input bit 7 is not sent.
- R4: Busy rises in the cycle after a write is accepted and stays high until the frame ends; a write while busy has no effect on the frame being sent.
- R5: The transmit done output pulses for exactly one cycle as busy falls, at the end of the second stop bit.
- R6: The receiver accepts a low start bit, eight data bits least significant first and a stop bit, then pulses receive done for one cycle and holds the byte on the read data output.
- R7: With parity mode on, read data bits 6..0 are the received bits 6..0 and bit 7 is 1 exactly when the eight received bits hold an even number of ones.
- R8: A low pulse on the receive line shorter than half a bit period is rejected and produces no received character.
- R9: A stop bit sampled low sets the framing error output together with receive done; a read strobe clears it.
- R10: Frames arriving back to back with a single stop bit are each received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_mode | input | 1 | 1 selects odd parity in slot 7 for both directions |
| wr_strobe | input | 1 | Loads wr_byte into the transmitter when idle |
| wr_byte | input | 8 | Byte to transmit |
| rd_strobe | input | 1 | Read acknowledge; clears the framing error |
| rd_byte | output | 8 | Last received character |
| ser_in | input | 1 | Asynchronous serial receive line |
| ser_out | output | 1 | Serial transmit line, high when idle |
| tx_busy | output | 1 | Transmission in progress |
| tx_done | output | 1 | One-cycle pulse per transmitted character |
| rx_done | output | 1 | One-cycle pulse per received character |
| rx_frame_err | output | 1 | Sticky flag for a stop bit sampled low |

## Verification
On every cycle the assertions check the following. Both done outputs are single-cycle pulses, and busy falls only together with transmit done. The transmit line is high in both stop slots. A write arriving while busy leaves the shift register untouched. A rejected start pulse returns the receiver to idle without a done pulse. The framing error clears after a read and rises only together with receive done. The bench scenarios are needed for the frame content and bit order on the line, the value of the parity bit and of the parity-error flag, the mid-bit sampling tolerance, and back-to-back reception with one stop bit.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
  parameter int DATA_W    = 8,
  parameter int OVS       = 16,
  parameter int STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = 1 + DATA_W + STOP_BITS;
  localparam int TCNT_W  = $clog2(OVS);
  localparam int BCNT_W  = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [TCNT_W-1:0]  tcnt_q, tcnt_d;
  logic [BCNT_W-1:0]  bcnt_q, bcnt_d;
  logic               busy_q, busy_d;
  logic               done_q, done_d;
  logic               top_bit;

  // slot DATA_W-1 carries either data or odd parity over the lower bits
  assign top_bit = par_en ? ~^load_data[DATA_W-2:0] : load_data[DATA_W-1];

  always_comb begin
    shreg_d = shreg_q;
    tcnt_d  = tcnt_q;
    bcnt_d  = bcnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (load && !busy_q) begin
      shreg_d = {{STOP_BITS{1'b1}}, top_bit, load_data[DATA_W-2:0], 1'b0};
      tcnt_d  = '0;
      bcnt_d  = '0;
      busy_d  = 1'b1;
    end else if (busy_q && tick) begin
      if (tcnt_q == TCNT_W'(OVS-1)) begin
        tcnt_d  = '0;
        shreg_d = {1'b1, shreg_q[FRAME_W-1:1]};
        if (bcnt_q == BCNT_W'(FRAME_W-1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign txd  = busy_q ? shreg_q[0] : 1'b1;
  assign busy = busy_q;
  assign done = done_q;

  // R4: a write during a frame does not disturb it
  a_r4_busy_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && load && !tick |=> $stable(shreg_q) && $stable(bcnt_q));
  // R5: done is a single-cycle pulse
  a_r5_tx_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R5: busy ends only with the done pulse
  a_r5_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R2: stop slots drive the line high
  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (bcnt_q >= BCNT_W'(FRAME_W-STOP_BITS)) |-> txd);
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              rx_in,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] data,
  output logic              done,
  output logic              frame_err
);
  localparam int TCNT_W    = $clog2(OVS);
  localparam int BCNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF_LAST = OVS/2 - 2;

  rx_state_t          state_q, state_d;
  logic [TCNT_W-1:0]  tcnt_q, tcnt_d;
  logic [BCNT_W-1:0]  bcnt_q, bcnt_d;
  logic [DATA_W-1:0]  shreg_q, shreg_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               done_q, done_d;
  logic               ferr_q, ferr_d;
  logic               stop_point;

  assign stop_point = (state_q == RX_STOP) && tick && (tcnt_q == TCNT_W'(OVS-1));

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bcnt_d  = bcnt_q;
    shreg_d = shreg_q;
    data_d  = data_q;
    done_d  = 1'b0;
    ferr_d  = rd_ack ? 1'b0 : ferr_q;
    if (tick) begin
      case (state_q)
        RX_IDLE: begin
          if (!rx_in) begin
            state_d = RX_START;
            tcnt_d  = '0;
          end
        end
        RX_START: begin
          if (rx_in) begin
            state_d = RX_IDLE;
          end else if (tcnt_q == TCNT_W'(HALF_LAST)) begin
            state_d = RX_DATA;
            tcnt_d  = '0;
            bcnt_d  = '0;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (tcnt_q == TCNT_W'(OVS-1)) begin
            tcnt_d  = '0;
            shreg_d = {rx_in, shreg_q[DATA_W-1:1]};
            if (bcnt_q == BCNT_W'(DATA_W-1)) state_d = RX_STOP;
            else                             bcnt_d  = bcnt_q + 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (tcnt_q == TCNT_W'(OVS-1)) begin
            state_d = RX_IDLE;
            tcnt_d  = '0;
            done_d  = 1'b1;
            data_d  = par_en ? {~^shreg_q, shreg_q[DATA_W-2:0]} : shreg_q;
            if (!rx_in) ferr_d = 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      shreg_q <= shreg_d;
      data_q  <= data_d;
      done_q  <= done_d;
      ferr_q  <= ferr_d;
    end
  end

  assign data      = data_q;
  assign done      = done_q;
  assign frame_err = ferr_q;

  // R6: receive done is a single-cycle pulse
  a_r6_rx_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: a start pulse that ends early aborts without a character
  a_r8_glitch_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START) && tick && rx_in |=> (state_q == RX_IDLE) && !done_q);
  // R9: a read clears the flag unless a new error arrives at once
  a_r9_ferr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !stop_point |=> !ferr_q);
  // R9: the flag rises only with a completed character
  a_r9_ferr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr_q) |-> done_q);
endmodule

// File: rtl/serial_port.sv
module serial_port #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int TX_STOP     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              par_mode,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_byte,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              rx_done,
  output logic              rx_frame_err
);
  logic rx_line;

  serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ser_in),
    .q     (rx_line)
  );

  serial_tx #(.DATA_W(DATA_W), .OVS(OVS), .STOP_BITS(TX_STOP)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bit_tick),
    .par_en    (par_mode),
    .load      (wr_strobe),
    .load_data (wr_byte),
    .txd       (ser_out),
    .busy      (tx_busy),
    .done      (tx_done)
  );

  serial_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bit_tick),
    .par_en    (par_mode),
    .rx_in     (rx_line),
    .rd_ack    (rd_strobe),
    .data      (rd_byte),
    .done      (rx_done),
    .frame_err (rx_frame_err)
  );
endmodule

// File: tb/serial_port_test.sv
`timescale 1ns/1ps
module serial_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       par_mode = 1'b0;
  logic       wr_strobe = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_byte;
  logic       ser_in = 1'b1;
  logic       ser_out, tx_busy, tx_done, rx_done, rx_frame_err;

  int checks = 0;
  int errors = 0;
  int rx_count = 0;
  logic [7:0] rx_last = 8'h00;
  logic [7:0] rx_prev = 8'h00;
  logic [1:0] tdiv = 2'd0;

  always #2.5 clk = ~clk;

  serial_port uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .par_mode(par_mode),
    .wr_strobe(wr_strobe), .wr_byte(wr_byte), .rd_strobe(rd_strobe),
    .rd_byte(rd_byte), .ser_in(ser_in), .ser_out(ser_out),
    .tx_busy(tx_busy), .tx_done(tx_done), .rx_done(rx_done),
    .rx_frame_err(rx_frame_err)
  );

  // tick every fourth clock, changed away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv     <= 2'd0;
      bit_tick <= 1'b0;
    end else begin
      tdiv     <= tdiv + 2'd1;
      bit_tick <= (tdiv == 2'd3);
    end
  end

  always @(negedge clk) begin
    if (rst_n && rx_done) begin
      rx_count <= rx_count + 1;
      rx_prev  <= rx_last;
      rx_last  <= rd_byte;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (bit_tick !== 1'b1) @(posedge clk);
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic par);
    logic b7;
    b7 = par ? ((d[0]+d[1]+d[2]+d[3]+d[4]+d[5]+d[6]) % 2 == 0) : d[7];
    return {2'b11, b7, d[6:0], 1'b0};
  endfunction

  // capture one transmitted frame; optionally write during it
  task automatic tx_frame(input string req, input logic [7:0] d, input logic par,
                          input logic poke);
    logic [10:0] got;
    par_mode = par;
    @(negedge clk); wr_strobe = 1'b1; wr_byte = d;
    @(negedge clk); wr_strobe = 1'b0;
    check("R4 busy after write", tx_busy, 1'b1);
    for (int b = 0; b < 11; b++) begin
      wait_ticks(b == 0 ? 8 : 16);
      @(negedge clk);
      got[b] = ser_out;
      if (poke && b == 2) begin
        wr_strobe = 1'b1; wr_byte = ~d;
        @(negedge clk); wr_strobe = 1'b0;
      end
    end
    check(req, got, exp_frame(d, par));
    check("R4 busy mid stop", tx_busy, 1'b1);
    wait_ticks(8);
    @(negedge clk);
    check("R5 tx_done at frame end", tx_done, 1'b1);
    check("R5 busy low at done", tx_busy, 1'b0);
    @(negedge clk);
    check("R5 tx_done one cycle", tx_done, 1'b0);
    check("R1 line idle high", ser_out, 1'b1);
  endtask

  // drive one frame on ser_in; stop_mode 0: one good stop, 1: bad stop
  task automatic rx_send(input logic [7:0] d, input int stop_mode);
    @(negedge clk); ser_in = 1'b0;
    for (int b = 0; b < 8; b++) begin
      wait_ticks(16); @(negedge clk); ser_in = d[b];
    end
    wait_ticks(16); @(negedge clk);
    if (stop_mode == 0) begin
      ser_in = 1'b1;
      wait_ticks(16);
    end else begin
      ser_in = 1'b0;
      wait_ticks(12); @(negedge clk);
      ser_in = 1'b1;
      wait_ticks(4);
    end
  endtask

  task automatic rx_frame(input string req, input logic [7:0] d, input logic par,
                          input logic [7:0] exp);
    int c0;
    par_mode = par;
    c0 = rx_count;
    rx_send(d, 0);
    wait_ticks(8); @(negedge clk);
    check(req, rx_count - c0, 1);
    check(req, rx_last, exp);
    check(req, rd_byte, exp);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 ser_out", ser_out, 1'b1);
    check("R1 tx_busy", tx_busy, 1'b0);
    check("R1 tx_done", tx_done, 1'b0);
    check("R1 rx_done", rx_done, 1'b0);
    check("R1 frame_err", rx_frame_err, 1'b0);
    check("R1 rd_byte", rd_byte, 8'h00);
  endtask

  task automatic test_glitch();
    int c0;
    c0 = rx_count;
    @(negedge clk); ser_in = 1'b0;
    wait_ticks(5); @(negedge clk); ser_in = 1'b1;
    wait_ticks(40); @(negedge clk);
    check("R8 short start rejected", rx_count - c0, 0);
    check("R8 no framing error", rx_frame_err, 1'b0);
  endtask

  task automatic test_back_to_back();
    int c0;
    par_mode = 1'b0;
    c0 = rx_count;
    rx_send(8'h5A, 0);
    rx_send(8'hC3, 0);
    wait_ticks(8); @(negedge clk);
    check("R10 two frames", rx_count - c0, 2);
    check("R10 first byte", rx_prev, 8'h5A);
    check("R10 second byte", rx_last, 8'hC3);
  endtask

  task automatic test_framing();
    int c0;
    par_mode = 1'b0;
    c0 = rx_count;
    rx_send(8'h11, 1);
    wait_ticks(20); @(negedge clk);
    check("R9 frame delivered", rx_count - c0, 1);
    check("R9 data kept", rd_byte, 8'h11);
    check("R9 frame_err set", rx_frame_err, 1'b1);
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    @(negedge clk);
    check("R9 frame_err cleared", rx_frame_err, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    tx_frame("R2 frame A5", 8'hA5, 1'b0, 1'b0);
    tx_frame("R2 frame 3C", 8'h3C, 1'b0, 1'b0);
    tx_frame("R3 parity even ones", 8'h03, 1'b1, 1'b0);
    tx_frame("R3 parity odd ones bit7 dropped", 8'h87, 1'b1, 1'b0);
    tx_frame("R4 write while busy ignored", 8'h96, 1'b0, 1'b1);
    rx_frame("R6 receive A5", 8'hA5, 1'b0, 8'hA5);
    rx_frame("R6 receive 3C", 8'h3C, 1'b0, 8'h3C);
    rx_frame("R7 parity good", 8'h83, 1'b1, 8'h03);
    rx_frame("R7 parity error flag", 8'h03, 1'b1, 8'h83);
    test_glitch();
    test_back_to_back();
    test_framing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule